// File: doc/BRIEF.md
# QRSS Test Pattern Generator

This block produces a serial quasi-random test stream for bit-error-ratio measurement. A 20-stage shift register advances on every enabled clock, and the XOR of two of its stages feeds the first stage back. Because the feedback polynomial is maximal-length, any nonzero state runs through all 1,048,575 nonzero states before it repeats. A zero-run limiter looks ahead along the register. When the bits that are about to leave the register are all zero, it forces a one onto the line, so no more than fourteen zeros ever appear in a row.

The stream leaves through a single registered output, one bit for each clock while the enable is high. A synchronous reseed puts the register back at a fixed nonzero starting point, so two ends of a link can line up on a known opening burst. An inject strobe flips exactly one emitted bit and leaves the register alone. An error detector downstream should therefore count exactly one error per strobe and then resynchronise at no cost.

Top module: `qrss_gen`

## Requirements
- R1: While reset is asserted and after it is released, `bit_out` is 0 and the register holds the seed value 0x80000, with stage 20 set and all other stages clear. The first enabled cycles after reset therefore produce the same burst as after a reseed (see R6).
- R2: Stage k is register bit k-1. The raw bit is stage 20. On each enabled cycle the register shifts toward stage 20, and stage 1 takes stage 20 XOR stage 17.
- R3: The emitted bit is forced to 1 whenever stages 19 down to 6 are all zero. Otherwise it equals the raw bit. In a stream with no injected errors, no run of zeros is longer than 14.
- R4: The output is registered. The bit computed from the state present at an enabled clock edge appears on `bit_out` just after that edge.
- R5: While `en` is low and `reseed` is low, both the register and `bit_out` keep their values. After `en` rises again, the stream continues exactly where it stopped.
- R6: A `reseed` pulse loads 0x80000 at the next edge whatever the value of `en`, and `bit_out` keeps its value in that cycle. The next 21 enabled bits are six ones, then fourteen zeros, then a one.
- R7: An `inject` pulse in a cycle with `en` high and `reseed` low inverts only the bit emitted in that cycle. This includes a bit that was forced to one. All later bits are unchanged.
- R8: `inject` has no effect in a cycle where `en` is low or `reseed` is high.
- R9: The register never reaches the all-zero state, so the stream never locks up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Advance the register and emit one bit this cycle |
| reseed | input | 1 | Synchronously reload the seed state; takes priority over `en` and `inject` |
| inject | input | 1 | Invert the bit emitted in this cycle |
| bit_out | output | 1 | Registered pattern bit |

## Verification
The interaction of interest is an inject strobe that lands on a bit the zero-run limiter has just forced to one. The bench provokes it by reseeding, which puts a long raw zero run straight ahead. It then raises `inject` on the second enabled cycle, where the limiter is known to force a one. The bench expects a 0 on the line in that cycle, and it expects every later bit of the burst and the following stream to match an independent model. A second case sends reseed and inject together with enable high, and the bench checks that the output holds and that the full seed burst follows untouched.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

  // Per-cycle action taken by the register stages.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_EMIT = 2'd2
  } qrss_act_e;

  // Priority: reload beats advance, advance beats hold.
  function automatic qrss_act_e decode_act(input logic en, input logic reseed);
    if (reseed)  return ACT_LOAD;
    else if (en) return ACT_EMIT;
    else         return ACT_HOLD;
  endfunction

endpackage

// File: rtl/qrss_rst_sync.sv
module qrss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/qrss_lfsr.sv
module qrss_lfsr
  import qrss_pkg::*;
#(
  parameter int          WIDTH = 20,
  parameter int          TAP   = 17,
  parameter logic [WIDTH-1:0] SEED = 20'h80000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qrss_act_e        act,
  output logic [WIDTH-1:0] state_o
);

  // A zero seed would lock the register; substitute a single one.
  localparam logic [WIDTH-1:0] SEED_SAFE = (SEED == '0) ? {{(WIDTH-1){1'b0}}, 1'b1} : SEED;

  logic [WIDTH-1:0] tap_mask;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fb;

  // Stage k sits in bit k-1; the last stage and stage TAP feed back.
  for (genvar g = 0; g < WIDTH; g++) begin : g_mask
    if ((g == WIDTH-1) || (g == TAP-1)) begin : g_on
      assign tap_mask[g] = 1'b1;
    end else begin : g_off
      assign tap_mask[g] = 1'b0;
    end
  end

  always_comb begin
    fb = ^(state_q & tap_mask);
  end

  always_comb begin
    unique case (act)
      ACT_LOAD: state_d = SEED_SAFE;
      ACT_EMIT: state_d = {state_q[WIDTH-2:0], fb};
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED_SAFE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/qrss_run_guard.sv
module qrss_run_guard #(
  parameter int RUN_MAX = 14
) (
  // window_i[RUN_MAX] is the raw bit; lower bits are the next RUN_MAX raw bits.
  input  logic [RUN_MAX:0] window_i,
  output logic             forced_o,
  output logic             shaped_o
);

  logic raw;

  assign raw = window_i[RUN_MAX];

  if (RUN_MAX == 0) begin : g_always
    assign forced_o = 1'b1;
  end else begin : g_look
    logic [RUN_MAX-1:0] ahead;
    assign ahead    = window_i[RUN_MAX-1:0];
    assign forced_o = ~|ahead;
  end

  always_comb begin
    shaped_o = raw | forced_o;
  end

endmodule

// File: rtl/qrss_out_stage.sv
module qrss_out_stage
  import qrss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  qrss_act_e act,
  input  logic      shaped_i,
  input  logic      inject_i,
  output logic      bit_o
);

  logic bit_q;
  logic bit_d;

  always_comb begin
    if (act == ACT_EMIT) bit_d = shaped_i ^ inject_i;
    else                 bit_d = bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/qrss_gen.sv
module qrss_gen
  import qrss_pkg::*;
#(
  parameter int               WIDTH   = 20,
  parameter int               TAP     = 17,
  parameter int               RUN_MAX = 14,
  parameter logic [WIDTH-1:0] SEED    = 20'h80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic reseed,
  input  logic inject,
  output logic bit_out
);

  localparam int WIN_LO = WIDTH - 1 - RUN_MAX;

  logic             rst_sync_n;
  qrss_act_e        act;
  logic [WIDTH-1:0] state_q;
  logic [RUN_MAX:0] window;
  logic             forced;
  logic             shaped;

  qrss_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    act = decode_act(en, reseed);
  end

  qrss_lfsr #(.WIDTH(WIDTH), .TAP(TAP), .SEED(SEED)) i_lfsr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .act     (act),
    .state_o (state_q)
  );

  assign window = state_q[WIDTH-1:WIN_LO];

  qrss_run_guard #(.RUN_MAX(RUN_MAX)) i_guard (
    .window_i (window),
    .forced_o (forced),
    .shaped_o (shaped)
  );

  qrss_out_stage i_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .act      (act),
    .shaped_i (shaped),
    .inject_i (inject),
    .bit_o    (bit_out)
  );

endmodule

// File: rtl/qrss_gen_chk.sv
module qrss_gen_chk #(
  parameter int               WIDTH   = 20,
  parameter int               RUN_MAX = 14,
  parameter logic [WIDTH-1:0] SEED    = 20'h80000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             reseed,
  input logic             inject,
  input logic [WIDTH-1:0] state,
  input logic             forced,
  input logic             shaped,
  input logic             bit_out
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R9
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

  // R3
  zero_window_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state[WIDTH-2 -: RUN_MAX] == '0) |-> (forced && shaped));

  // R4
  emit_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en && !reseed && !inject) |=> (bit_out == $past(shaped)));

  // R7
  inject_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en && !reseed && inject) |=> (bit_out != $past(shaped)));

  // R5
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !en && !reseed) |=> ($stable(state) && $stable(bit_out)));

  // R6
  reseed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reseed) |=> ((state == SEED) && $stable(bit_out)));

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en && !reseed) |=> (state[WIDTH-1:1] == $past(state[WIDTH-2:0])));

endmodule

bind qrss_gen qrss_gen_chk #(
  .WIDTH   (WIDTH),
  .RUN_MAX (RUN_MAX),
  .SEED    (SEED)
) i_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en      (en),
  .reseed  (reseed),
  .inject  (inject),
  .state   (state_q),
  .forced  (forced),
  .shaped  (shaped),
  .bit_out (bit_out)
);

// File: tb/test_qrss_gen.sv
module test_qrss_gen;

  logic clk = 1'b0;
  logic rst_n;
  logic en;
  logic reseed;
  logic inject;
  logic bit_out;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  logic [19:0] m;          // independent model of the register
  logic        last_bit;   // last value expected on bit_out
  int          zrun;
  int          zmax;

  always #10 clk = ~clk;   // 50 MHz

  qrss_gen i_qrss_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .reseed  (reseed),
    .inject  (inject),
    .bit_out (bit_out)
  );

  // Emitted bit per R2/R3: stage 20 raw, forced 1 when stages 19..6 are zero.
  function automatic logic model_bit(input logic [19:0] s);
    return s[19] | (s[18:5] == 14'd0);
  endfunction

  function automatic logic [19:0] model_next(input logic [19:0] s);
    return {s[18:0], s[19] ^ s[16]};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: bit_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle, update the model, sample after the edge.
  task automatic step(input logic e, input logic r, input logic inj, input string req);
    @(negedge clk);
    en = e; reseed = r; inject = inj;
    if (r) begin
      m = 20'h80000;
    end else if (e) begin
      last_bit = model_bit(m) ^ inj;
      m = model_next(m);
    end
    @(posedge clk);
    #2;
    check(req, bit_out, last_bit);
    if (e && !r && !inj) begin
      if (bit_out == 1'b0) zrun++;
      else                 zrun = 0;
      if (zrun > zmax) zmax = zrun;
    end else begin
      zrun = 0;
    end
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    en = 1'b0; reseed = 1'b0; inject = 1'b0;
  endtask

  // Six ones, fourteen zeros, one: literal from R6.
  task automatic check_burst(input string req);
    for (int i = 0; i < 21; i++) begin
      logic lit;
      lit = (i < 6 || i == 20) ? 1'b1 : 1'b0;
      step(1'b1, 1'b0, 1'b0, req);
      check(req, bit_out, lit);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; reseed = 1'b0; inject = 1'b0;
    m = 20'h80000; last_bit = 1'b0; zrun = 0; zmax = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 during reset", bit_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1 after release", bit_out, 1'b0);
    // R1: register starts at the seed, so the burst follows directly.
    check_burst("R1 seed burst");
  endtask

  task automatic t_stream();
    // R2 R3 R9: long comparison with zero-run tracking.
    for (int i = 0; i < 6000; i++) step(1'b1, 1'b0, 1'b0, "R2 stream");
    n_cmp++;
    if (zmax > 14 || zmax < 1) begin
      n_bad++;
      $display("FAIL R3/R9: longest zero run=%0d expected=1..14", zmax);
    end
  endtask

  task automatic t_hold();
    logic held;
    held = last_bit;
    // R5 R8: no advance, inject ignored while disabled.
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, i[0], "R8 inject while disabled");
      check("R5 hold", bit_out, held);
    end
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, "R5 resume");
  endtask

  task automatic t_inject();
    // R4 R7: one flipped bit, the rest untouched.
    step(1'b1, 1'b0, 1'b1, "R7 inverted bit");
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, 1'b0, "R7 after inject");
  endtask

  task automatic t_reseed_inject();
    // R6 R8: reseed with en and inject high; output holds, burst follows.
    step(1'b1, 1'b1, 1'b1, "R8 inject during reseed");
    check_burst("R6 burst after reseed");
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b0, "R6 tail");
    // R6: reseed while disabled also reloads.
    step(1'b0, 1'b1, 1'b0, "R6 reseed disabled");
    check_burst("R6 burst after idle reseed");
  endtask

  task automatic t_inject_forced();
    // R7: inject on a forced one (second bit of the burst) yields 0.
    step(1'b1, 1'b1, 1'b0, "R6 reseed");
    step(1'b1, 1'b0, 1'b0, "R6 burst bit0");
    step(1'b1, 1'b0, 1'b1, "R7 forced one inverted");
    check("R7 forced one inverted literal", bit_out, 1'b0);
    for (int i = 0; i < 80; i++) step(1'b1, 1'b0, 1'b0, "R7 after forced inject");
  endtask

  initial begin
    t_reset();
    t_stream();
    t_hold();
    t_inject();
    t_reseed_inject();
    t_inject_forced();
    idle_inputs();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule